// File: doc/BRIEF.md
# Dual-Mode Serial I/O Unit

This unit holds one 4-bit register that a small 4-bit controller core uses for serial input and output. Bit 0 of a 4-bit mode register sets what the register does. In shift mode it moves left by one place on every instruction-cycle strobe, and the synchronised serial input enters at the low end. In counter mode it counts down by one for each high-to-low transition of the serial input, as seen across successive instruction cycles.

The core reaches the unit through an exchange port. One exchange writes the accumulator value into the register, returns the old register contents, and copies the carry flag into a one-bit clock latch. The serial output pin and the serial clock pin are driven from the mode bits, the register's top bit, the clock latch and the instruction-cycle strobe. A new mode value is held pending and applies from the next strobe onward. The input is synchronised by a chain of flops, the active mode register, the pending mode register and the clock latch all clear on a synchronous reset.

Top module: `sio_unit`

## Requirements
- R1: Active mode bit 0 selects the function: 1 selects down counter, 0 selects left shifter. The selection is applied on instruction-cycle strobes.
- R2: In counter mode, a strobe at which the previous sampled input was 1 and the current sampled input is 0 decrements the register by one. The count wraps from 0 to 15.
- R3: In counter mode, an input held at a constant level across strobes leaves the count unchanged. A low pulse that spans two or more strobes decrements the count exactly once.
- R4: In shift mode, every strobe loads the register with {reg[2:0], sampled input}.
- R5: The serial output is driven as follows. In counter mode it equals active mode bit 3. In shift mode with bit 3 set, it equals register bit 3. In shift mode with bit 3 clear, it is 0 while shifting continues.
- R6: `regOut` always shows the register. An exchange loads the register from `accIn` and the clock latch from `carryIn` on the same edge. An exchange that coincides with a strobe takes priority over the shift or count.
- R7: In counter mode the serial clock pin equals the clock latch.
- R8: In shift mode the serial clock pin equals the clock latch ANDed with the instruction-cycle strobe, so it is 0 whenever the latch is 0.
- R9: Mode bit 1 has no effect on the register, the serial output or the serial clock.
- R10: A mode load becomes active at the next strobe. Until that strobe, the previous mode governs all behaviour.
- R11: Synchronous reset clears the register, both mode registers and the clock latch, so the serial output and serial clock are both 0.
- R12: When there is neither a strobe nor an exchange, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cycStrobe | input | 1 | One-clock pulse marking each instruction cycle |
| modeLoad | input | 1 | Writes `modeData` into the pending mode register |
| modeData | input | 4 | New mode value (bit 0 counter select, bit 3 output enable/level) |
| xchg | input | 1 | Exchange strobe |
| accIn | input | 4 | Accumulator value written into the register on exchange |
| carryIn | input | 1 | Carry flag copied into the clock latch on exchange |
| regOut | output | 4 | Current register contents, returned to the accumulator |
| siPin | input | 1 | Asynchronous serial input |
| soPin | output | 1 | Serial output |
| skPin | output | 1 | Serial clock output |

## Verification
The hardest cases to reach from the ports are decrements that depend on the input sample taken at an earlier strobe. Examples are a falling edge that straddles a mode switch, and a count that wraps below zero. The stimulus reaches these by first exchanging a known value into the register, including zero to test the wrap. It then loads counter mode without a strobe in between, and steps the input through several strobes with a long high, a long low and a repeated low. A separate step asserts an exchange in the same clock as a strobe, to show that the exchange wins while the input sample still advances.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int MODE_W = 4;
  localparam int MODE_COUNT_BIT = 0;
  localparam int MODE_SO_BIT = 3;

  typedef struct packed {
    logic shiftEn;
    logic countEn;
    logic xchgEn;
    logic counterMode;
    logic soEnable;
    logic cycPhase;
  } sioStrobes_t;
endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycStrobe,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeData,
  input  logic              xchg,
  input  logic              siPin,
  output sioStrobes_t       strb,
  output logic              siBit
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic siSync;
  logic siPrev;
  logic [MODE_W-1:0] modePend;
  logic [MODE_W-1:0] modeAct;
  logic counterMode;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], siPin};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= siPin;
      end
    end
  endgenerate

  assign siSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      siPrev   <= 1'b0;
      modePend <= '0;
      modeAct  <= '0;
    end else begin
      if (modeLoad)  modePend <= modeData;
      if (cycStrobe) begin
        siPrev  <= siSync;
        modeAct <= modePend;
      end
    end
  end

  assign counterMode      = modeAct[MODE_COUNT_BIT];
  assign strb.counterMode = counterMode;
  assign strb.soEnable    = modeAct[MODE_SO_BIT];
  assign strb.cycPhase    = cycStrobe;
  assign strb.xchgEn      = xchg;
  assign strb.shiftEn     = cycStrobe & ~counterMode & ~xchg;
  assign strb.countEn     = cycStrobe & counterMode & ~xchg & siPrev & ~siSync;
  assign siBit            = siSync;

  assert_one_op_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.shiftEn, strb.countEn, strb.xchgEn}));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cycStrobe |=> $stable(modeAct));

  assert_mode_take_R10: assert property (@(posedge clk) disable iff (rst)
    cycStrobe |=> modeAct == $past(modePend));

  assert_edge_once_R3: assert property (@(posedge clk) disable iff (rst)
    strb.countEn |=> !strb.countEn);
endmodule

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  sioStrobes_t       strb,
  input  logic              siBit,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] regOut,
  output logic              soPin,
  output logic              skPin
);
  logic [DATA_W-1:0] dataReg;
  logic skLatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= '0;
      skLatch <= 1'b0;
    end else if (strb.xchgEn) begin
      dataReg <= accIn;
      skLatch <= carryIn;
    end else if (strb.shiftEn) begin
      dataReg <= {dataReg[DATA_W-2:0], siBit};
    end else if (strb.countEn) begin
      dataReg <= dataReg - DATA_W'(1);
    end
  end

  assign regOut = dataReg;
  assign soPin  = strb.counterMode ? strb.soEnable
                                   : (strb.soEnable & dataReg[DATA_W-1]);
  assign skPin  = skLatch & (strb.counterMode | strb.cycPhase);

  assert_count_dec_R2: assert property (@(posedge clk) disable iff (rst)
    strb.countEn |=> dataReg == $past(dataReg) - DATA_W'(1));

  assert_shift_left_R4: assert property (@(posedge clk) disable iff (rst)
    strb.shiftEn |=> dataReg == {$past(dataReg[DATA_W-2:0]), $past(siBit)});

  assert_xchg_load_R6: assert property (@(posedge clk) disable iff (rst)
    strb.xchgEn |=> (dataReg == $past(accIn)) && (skLatch == $past(carryIn)));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !(strb.xchgEn | strb.shiftEn | strb.countEn) |=> $stable(dataReg));

  assert_sk_low_R8: assert property (@(posedge clk) disable iff (rst)
    !skLatch |-> !skPin);

  assert_reset_R11: assert property (@(posedge clk)
    $past(rst) |-> (dataReg == '0) && !soPin && !skPin);
endmodule

// File: rtl/sio_unit.sv
module sio_unit
  import sio_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycStrobe,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeData,
  input  logic              xchg,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] regOut,
  input  logic              siPin,
  output logic              soPin,
  output logic              skPin
);
  sioStrobes_t strb;
  logic siBit;

  sio_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .cycStrobe(cycStrobe), .modeLoad(modeLoad),
    .modeData(modeData), .xchg(xchg), .siPin(siPin),
    .strb(strb), .siBit(siBit)
  );

  sio_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .siBit(siBit), .accIn(accIn),
    .carryIn(carryIn), .regOut(regOut), .soPin(soPin), .skPin(skPin)
  );
endmodule

// File: tb/sio_unit_test.sv
module sio_unit_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cycStrobe = 1'b0, modeLoad = 1'b0, xchg = 1'b0, carryIn = 1'b0, siPin = 1'b1;
  logic [3:0] modeData = '0, accIn = '0, regOut;
  logic soPin, skPin;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  typedef struct { int kind; logic [3:0] val; string req; } expItem_t;
  expItem_t expQ[$];
  event sampleEv;

  logic [3:0] mReg = '0, mMode = '0, mPend = '0;
  logic mLatch = 1'b0, mPrev = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sio_unit uut (
    .clk(clk), .rst(rst), .cycStrobe(cycStrobe), .modeLoad(modeLoad),
    .modeData(modeData), .xchg(xchg), .accIn(accIn), .carryIn(carryIn),
    .regOut(regOut), .siPin(siPin), .soPin(soPin), .skPin(skPin)
  );

  // monitor: pop expected items and compare to live outputs
  initial forever begin
    @(sampleEv);
    while (expQ.size() > 0) begin
      expItem_t it;
      logic [3:0] act;
      it = expQ.pop_front();
      act = (it.kind == 0) ? regOut : (it.kind == 1) ? {3'b0, soPin} : {3'b0, skPin};
      nChecks++;
      if (act !== it.val) begin
        nFails++;
        $display("FAIL %s kind=%0d: actual %h expected %h", it.req, it.kind, act, it.val);
      end
    end
  end

  task automatic pushExp(int kind, logic [3:0] val, string req);
    expItem_t it;
    it.kind = kind; it.val = val; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic flush();
    #1 -> sampleEv;
    #1;
  endtask

  function automatic logic expSo();
    return mMode[0] ? mMode[3] : (mMode[3] & mReg[3]);
  endfunction

  task automatic checkAll(string req);
    pushExp(0, mReg, req);
    pushExp(1, {3'b0, expSo()}, (mMode[0] ? "R5" : req));
    pushExp(2, {3'b0, mLatch & mMode[0]}, (mMode[0] ? "R7" : "R8"));
    flush();
  endtask

  // one instruction cycle with the given serial input level
  task automatic cyc(logic si, string req);
    logic cur;
    siPin = si;
    repeat (3) @(negedge clk);
    cycStrobe = 1'b1;
    pushExp(2, {3'b0, mLatch}, (mMode[0] ? "R7" : "R8"));
    flush();
    @(negedge clk);
    cycStrobe = 1'b0;
    cur = si;
    if (mMode[0]) begin
      if (mPrev && !cur) mReg = mReg - 4'd1;
    end else begin
      mReg = {mReg[2:0], cur};
    end
    mPrev = cur;
    mMode = mPend;
    checkAll(req);
  endtask

  task automatic loadMode(logic [3:0] m);
    modeLoad = 1'b1; modeData = m;
    @(negedge clk);
    modeLoad = 1'b0;
    mPend = m;
    checkAll("R10");
  endtask

  task automatic doXchg(logic [3:0] a, logic c);
    pushExp(0, mReg, "R6");
    flush();
    xchg = 1'b1; accIn = a; carryIn = c;
    @(negedge clk);
    xchg = 1'b0;
    mReg = a; mLatch = c;
    checkAll("R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checkAll("R11");
    cyc(1'b1, "R11");

    doXchg(4'hA, 1'b1);
    cyc(1'b1, "R4");
    cyc(1'b0, "R4");
    loadMode(4'b1000);
    pushExp(1, 1'b0, "R10"); flush();
    cyc(1'b1, "R10");
    cyc(1'b0, "R5");
    cyc(1'b1, "R5");
    cyc(1'b1, "R4");
    for (int i = 0; i < 16; i++) cyc(1'($urandom_range(0, 1)), "R4");

    doXchg(4'h3, 1'b1);
    loadMode(4'b1001);
    cyc(1'b1, "R1");
    cyc(1'b1, "R3");
    cyc(1'b0, "R2");
    cyc(1'b0, "R3");
    cyc(1'b0, "R3");
    cyc(1'b1, "R3");
    cyc(1'b0, "R2");
    cyc(1'b1, "R2");
    doXchg(4'h0, 1'b0);
    cyc(1'b0, "R2");
    pushExp(0, 4'hF, "R2"); flush();
    cyc(1'b1, "R12");
    repeat (5) @(negedge clk);
    checkAll("R12");

    loadMode(4'b0011);
    cyc(1'b1, "R9");
    cyc(1'b0, "R9");
    cyc(1'b1, "R9");
    loadMode(4'b1010);
    cyc(1'b1, "R9");
    doXchg(4'h5, 1'b1);
    cyc(1'b0, "R9");
    cyc(1'b1, "R9");

    loadMode(4'b0001);
    cyc(1'b1, "R1");
    siPin = 1'b0;
    repeat (3) @(negedge clk);
    cycStrobe = 1'b1; xchg = 1'b1; accIn = 4'h9; carryIn = 1'b0;
    @(negedge clk);
    cycStrobe = 1'b0; xchg = 1'b0;
    mReg = 4'h9; mLatch = 1'b0; mPrev = 1'b0; mMode = mPend;
    checkAll("R6");
    cyc(1'b0, "R6");

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mReg = '0; mMode = '0; mPend = '0; mLatch = 1'b0; mPrev = 1'b0;
    checkAll("R11");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL timeout R11: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule